// File: doc/BRIEF.md
# Receive FIFO with Status and Error Flags

This block is a single-clock receive FIFO with a small register set beside it. A producer pushes 32-bit words through a write port that can stall the producer with a wait signal. A consumer, normally a DMA engine, pops words through a read port whose data shows the oldest stored word without any delay.

The block reports its fill state with live Full and Empty indications. It also drives a drain request that rises once the fill level reaches a programmable watermark. The request is held until software asks for it to be evaluated again. Three sticky error flags record protocol faults: a write into a full FIFO that is dropped, a read from an empty FIFO, and a write that had to be held off with wait states. Each flag has its own mask, and any unmasked flag drives one shared error output.

Software reaches the block through a word-wide register port with four addresses: status, control, watermark and one spare. A control bit performs a soft FIFO reset that empties the FIFO and clears the flags.

Top module: `rx_fifo_status`

## Requirements
- R1: The FIFO stores up to 16 words of 32 bits in arrival order. `rd_data` shows the oldest stored word in the same cycle. `rd_en` with the FIFO not empty removes that word at the clock edge.
- R2: `fifo_full` is 1 exactly when 16 words are stored and `fifo_empty` is 1 exactly when none are. Both follow the fill level after every edge and are never sticky. They also read back as status bits 18 (full) and 16 (empty), with LSB-0 numbering.
- R3: `rd_en` while the FIFO is empty leaves the FIFO unchanged and shows `rd_data` as zero. It sets the underflow flag, status bit 21, at the next edge.
- R4: When waiting is disabled (control bit 1 = 0), `wr_valid` while the FIFO is full drops the word and sets the overflow flag, status bit 20, at the next edge.
- R5: When waiting is enabled (control bit 1 = 1), `wr_valid` while the FIFO is full raises `wr_wait` in the same cycle. The word is not stored, and the wait flag, status bit 22, is set at the next edge.
- R6: `drain_req` and status bit 17 equal (held | level >= watermark). The held term is set by any cycle in which level >= watermark. It is cleared only by writing a one to status bit 17 or by a soft reset. The watermark is bits [4:0] at address 2.
- R7: The wait, underflow and overflow flags stay set until a write to the status register (address 0) with a one in their bit. If a clearing write and a new event of the same kind fall in the same cycle, the flag stays set.
- R8: `err_out` is 1 when any flag is set whose mask is 0. The masks are control bits 4 (wait), 5 (underflow) and 6 (overflow). A masked flag still reads as set in the status register.
- R9: `cfg_rdata` shows, with no delay, the status word at address 0, the control word at address 1 (bit 1 wait enable, bits 6:4 masks, bit 0 always 0), the watermark at address 2 and zero at address 3. Status bit 19 and all status bits not named above read as 0.
- R10: Writing control (address 1) with bit 0 = 1 empties the FIFO and clears the three flags and the held alarm term at that edge. A FIFO write in the same cycle is dropped. The other control fields take the written values.
- R11: After the synchronous reset `rst`, the FIFO is empty, the flags, control and watermark are 0, and so `drain_req` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | 32 | Word offered by the producer |
| wr_wait | output | 1 | Producer must hold its word (FIFO full, waiting enabled) |
| rd_en | input | 1 | Consumer takes the oldest word |
| rd_data | output | 32 | Oldest word, zero when empty |
| cfg_sel | input | 2 | Register address |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel` |
| fifo_full | output | 1 | FIFO holds 16 words |
| fifo_empty | output | 1 | FIFO holds no word |
| drain_req | output | 1 | Watermark alarm toward the DMA engine |
| err_out | output | 1 | Any unmasked sticky error flag |

## Verification
Two functions can fall in the same cycle: a software clear of a sticky flag and a fresh hardware event of the same kind. The bench fills the FIFO and then writes a one to the overflow bit in the same cycle as another write into the full FIFO. It expects the overflow bit to read back as set, and after a lone clearing write it expects the bit to read as clear. The same collision occurs for all flags and for the alarm re-evaluation during the seeded random phase, where a cycle-level reference model judges every status readback and output.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        SEL_STAT  = 2'd0,
        SEL_CTRL  = 2'd1,
        SEL_WMARK = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    // status word bit positions (LSB-0)
    localparam int ST_EMPTY = 16;
    localparam int ST_ALARM = 17;
    localparam int ST_FULL  = 18;
    localparam int ST_FRAME = 19;
    localparam int ST_OVF   = 20;
    localparam int ST_UNF   = 21;
    localparam int ST_WAIT  = 22;

    // control word bit positions
    localparam int CT_CLEAR  = 0;
    localparam int CT_WAITEN = 1;
    localparam int CT_MWAIT  = 4;
    localparam int CT_MUNF   = 5;
    localparam int CT_MOVF   = 6;

    typedef struct packed {
        logic wait_hit;
        logic unf;
        logic ovf;
    } err_t;

    typedef struct packed {
        logic wait_en;
        logic m_wait;
        logic m_unf;
        logic m_ovf;
    } ctrl_t;

    function automatic logic [REG_W-1:0] pack_status(err_t e, logic full, logic alarm, logic empty);
        logic [REG_W-1:0] r;
        r           = '0;
        r[ST_WAIT]  = e.wait_hit;
        r[ST_UNF]   = e.unf;
        r[ST_OVF]   = e.ovf;
        r[ST_FRAME] = 1'b0;
        r[ST_FULL]  = full;
        r[ST_ALARM] = alarm;
        r[ST_EMPTY] = empty;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c);
        logic [REG_W-1:0] r;
        r            = '0;
        r[CT_WAITEN] = c.wait_en;
        r[CT_MWAIT]  = c.m_wait;
        r[CT_MUNF]   = c.m_unf;
        r[CT_MOVF]   = c.m_ovf;
        return r;
    endfunction

    function automatic logic err_any(err_t e, ctrl_t c);
        return (e.wait_hit & ~c.m_wait) | (e.unf & ~c.m_unf) | (e.ovf & ~c.m_ovf);
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wptr <= step_ptr(wptr);
            end
            if (pop) begin
                rptr <= step_ptr(rptr);
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rptr];

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
    import rxf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  err_t set_ev,
    input  err_t clr_req,
    input  logic reeval,
    input  logic fifo_clr,
    input  logic level_hit,
    output err_t flags,
    output logic alarm_hold
);

    err_t flags_n;
    logic hold_n;

    always_comb begin
        if (fifo_clr) begin
            flags_n = '0;
            hold_n  = 1'b0;
        end else begin
            // a new event wins over a software clear in the same cycle
            flags_n = err_t'(set_ev | (flags & ~clr_req));
            hold_n  = reeval ? 1'b0 : (alarm_hold | level_hit);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags      <= '0;
            alarm_hold <= 1'b0;
        end else begin
            flags      <= flags_n;
            alarm_hold <= hold_n;
        end
    end

endmodule

// File: rtl/rxf_regs.sv
module rxf_regs
    import rxf_pkg::*;
#(
    parameter int WM_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_sel_e         sel,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] status_word,
    output ctrl_t            ctrl,
    output logic [WM_W-1:0]  wmark,
    output err_t             clr_req,
    output logic             reeval,
    output logic             fifo_clr,
    output logic [REG_W-1:0] rdata
);

    logic stat_wr;
    logic ctrl_wr;
    logic wm_wr;
    logic wdata_unused;

    assign stat_wr = we && (sel == SEL_STAT);
    assign ctrl_wr = we && (sel == SEL_CTRL);
    assign wm_wr   = we && (sel == SEL_WMARK);

    assign clr_req.wait_hit = stat_wr & wdata[ST_WAIT];
    assign clr_req.unf      = stat_wr & wdata[ST_UNF];
    assign clr_req.ovf      = stat_wr & wdata[ST_OVF];
    assign reeval           = stat_wr & wdata[ST_ALARM];
    assign fifo_clr         = ctrl_wr & wdata[CT_CLEAR];
    assign wdata_unused     = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            wmark <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl.wait_en <= wdata[CT_WAITEN];
                ctrl.m_wait  <= wdata[CT_MWAIT];
                ctrl.m_unf   <= wdata[CT_MUNF];
                ctrl.m_ovf   <= wdata[CT_MOVF];
            end
            if (wm_wr) begin
                wmark <= wdata[WM_W-1:0];
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_STAT:  rdata = status_word;
            SEL_CTRL:  rdata = pack_ctrl(ctrl);
            SEL_WMARK: rdata = REG_W'(wmark);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/rx_fifo_status.sv
module rx_fifo_status
    import rxf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_wait,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [1:0]        cfg_sel,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              drain_req,
    output logic              err_out
);

    localparam int CW   = $clog2(DEPTH + 1);
    localparam int WM_W = CW;

    logic [DATA_W-1:0] head;
    logic [CW-1:0]     count;
    logic [WM_W-1:0]   wmark;
    logic              push;
    logic              pop;
    logic              level_hit;
    logic              alarm_hold;
    logic              reeval;
    logic              fifo_clr;
    logic [REG_W-1:0]  status_word;
    err_t              set_ev;
    err_t              clr_req;
    err_t              flags;
    ctrl_t             ctrl;

    assign fifo_full  = (count == CW'(DEPTH));
    assign fifo_empty = (count == '0);

    // handshake and fault detection
    assign push             = wr_valid & ~fifo_full & ~fifo_clr;
    assign pop              = rd_en & ~fifo_empty & ~fifo_clr;
    assign wr_wait          = wr_valid & fifo_full & ctrl.wait_en;
    assign set_ev.wait_hit  = wr_valid & fifo_full & ctrl.wait_en;
    assign set_ev.ovf       = wr_valid & fifo_full & ~ctrl.wait_en;
    assign set_ev.unf       = rd_en & fifo_empty;

    assign rd_data   = fifo_empty ? '0 : head;
    assign level_hit = (count >= wmark);
    assign drain_req = alarm_hold | level_hit;
    assign err_out   = err_any(flags, ctrl);

    assign status_word = pack_status(flags, fifo_full, drain_req, fifo_empty);

    rxf_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) store_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (fifo_clr),
        .push  (push),
        .pop   (pop),
        .wdata (wr_data),
        .head  (head),
        .count (count)
    );

    rxf_flags flags_i (
        .clk        (clk),
        .rst        (rst),
        .set_ev     (set_ev),
        .clr_req    (clr_req),
        .reeval     (reeval),
        .fifo_clr   (fifo_clr),
        .level_hit  (level_hit),
        .flags      (flags),
        .alarm_hold (alarm_hold)
    );

    rxf_regs #(
        .WM_W (WM_W)
    ) regs_i (
        .clk         (clk),
        .rst         (rst),
        .sel         (reg_sel_e'(cfg_sel)),
        .we          (cfg_we),
        .wdata       (cfg_wdata),
        .status_word (status_word),
        .ctrl        (ctrl),
        .wmark       (wmark),
        .clr_req     (clr_req),
        .reeval      (reeval),
        .fifo_clr    (fifo_clr),
        .rdata       (cfg_rdata)
    );

endmodule

// File: rtl/rx_fifo_status_chk.sv
module rx_fifo_status_chk
    import rxf_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  wr_valid,
    input logic  rd_en,
    input logic  wr_wait,
    input logic  fifo_full,
    input logic  fifo_empty,
    input logic  drain_req,
    input logic  err_out,
    input err_t  flags,
    input ctrl_t ctrl,
    input err_t  clr_req,
    input logic  reeval,
    input logic  fifo_clr
);

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty)); // R2

    AST_UNF_RAISE: assert property (@(posedge clk) disable iff (rst)
        rd_en && fifo_empty && !fifo_clr |=> flags.unf); // R3

    AST_OVF_RAISE: assert property (@(posedge clk) disable iff (rst)
        wr_valid && fifo_full && !ctrl.wait_en && !fifo_clr |=> flags.ovf); // R4

    AST_WAIT_RAISE: assert property (@(posedge clk) disable iff (rst)
        wr_wait && !fifo_clr |=> flags.wait_hit); // R5

    AST_ALARM_HELD: assert property (@(posedge clk) disable iff (rst)
        drain_req && !reeval && !fifo_clr |=> drain_req); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        flags.ovf && !clr_req.ovf && !fifo_clr |=> flags.ovf); // R7

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        ctrl.m_wait && ctrl.m_unf && ctrl.m_ovf |-> !err_out); // R8

    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> fifo_empty && (flags == '0)); // R10

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> fifo_empty && (flags == '0) && drain_req); // R11

endmodule

bind rx_fifo_status rx_fifo_status_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .rd_en      (rd_en),
    .wr_wait    (wr_wait),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .drain_req  (drain_req),
    .err_out    (err_out),
    .flags      (flags),
    .ctrl       (ctrl),
    .clr_req    (clr_req),
    .reeval     (reeval),
    .fifo_clr   (fifo_clr)
);

// File: tb/rx_fifo_status_tb_top.sv
module rx_fifo_status_tb_top;

    localparam int DW  = 32;
    localparam int DEP = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_wait;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic [1:0]    cfg_sel = 2'd0;
    logic          cfg_we = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          fifo_full;
    logic          fifo_empty;
    logic          drain_req;
    logic          err_out;

    always #5 clk = ~clk;

    rx_fifo_status #(.DATA_W(DW), .DEPTH(DEP)) dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_wait(wr_wait),
        .rd_en(rd_en), .rd_data(rd_data), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .drain_req(drain_req), .err_out(err_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [DW-1:0] mq[$];
    bit m_ovf, m_unf, m_wait, m_hold, m_wen, m_mw, m_mu, m_mo;
    int m_wm;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_alarm();
        return m_hold || (mq.size() >= m_wm);
    endfunction

    function automatic logic [31:0] exp_status();
        return {9'b0, m_wait, m_unf, m_ovf, 1'b0, mq.size() == DEP, exp_alarm(), mq.size() == 0, 16'b0};
    endfunction

    function automatic logic [31:0] exp_ctrl();
        return {25'b0, m_mo, m_mu, m_mw, 2'b0, m_wen, 1'b0};
    endfunction

    function automatic bit exp_err();
        return (m_wait && !m_mw) || (m_unf && !m_mu) || (m_ovf && !m_mo);
    endfunction

    // one clock cycle: drive at negedge, check combinational, model, check registered
    task automatic step(bit wv, logic [31:0] wd, bit re, logic [1:0] ra, bit rwe, logic [31:0] rwd);
        bit full_m, empty_m, clr, cmp;
        wr_valid = wv; wr_data = wd; rd_en = re;
        cfg_sel = ra; cfg_we = rwe; cfg_wdata = rwd;
        #1;
        full_m  = (mq.size() == DEP);
        empty_m = (mq.size() == 0);
        chk("R1 rd_data", rd_data, empty_m ? 32'd0 : mq[0]);
        chk("R5 wr_wait", {31'b0, wr_wait}, {31'b0, wv && m_wen && full_m});
        case (ra)
            2'd0: chk("R9 status read", cfg_rdata, exp_status());
            2'd1: chk("R9 control read", cfg_rdata, exp_ctrl());
            2'd2: chk("R9 watermark read", cfg_rdata, 32'(m_wm));
            default: chk("R9 spare read", cfg_rdata, 32'd0);
        endcase
        clr = rwe && (ra == 2'd1) && rwd[0];
        cmp = (mq.size() >= m_wm);
        if (clr) begin
            mq.delete();
            m_ovf = 0; m_unf = 0; m_wait = 0; m_hold = 0;
        end else begin
            if (rwe && ra == 2'd0) begin
                if (rwd[22]) m_wait = 0;
                if (rwd[21]) m_unf = 0;
                if (rwd[20]) m_ovf = 0;
                m_hold = rwd[17] ? 1'b0 : (m_hold || cmp);
            end else begin
                m_hold = m_hold || cmp;
            end
            if (re && empty_m) m_unf = 1;
            if (wv && full_m && !m_wen) m_ovf = 1;
            if (wv && full_m && m_wen) m_wait = 1;
            if (re && !empty_m) void'(mq.pop_front());
            if (wv && !full_m) mq.push_back(wd);
        end
        if (rwe && ra == 2'd1) begin
            m_wen = rwd[1]; m_mw = rwd[4]; m_mu = rwd[5]; m_mo = rwd[6];
        end
        if (rwe && ra == 2'd2) m_wm = int'(rwd[4:0]);
        @(posedge clk);
        @(negedge clk);
        chk("R2 full", {31'b0, fifo_full}, {31'b0, mq.size() == DEP});
        chk("R2 empty", {31'b0, fifo_empty}, {31'b0, mq.size() == 0});
        chk("R6 drain_req", {31'b0, drain_req}, {31'b0, exp_alarm()});
        chk("R8 err_out", {31'b0, err_out}, {31'b0, exp_err()});
    endtask

    task automatic idle();
        step(0, 32'd0, 0, 2'd0, 0, 32'd0);
    endtask

    task automatic peek_stat();
        wr_valid = 0; rd_en = 0; cfg_we = 0; cfg_sel = 2'd0;
        #1;
    endtask

    task automatic fill(int n);
        for (int i = 0; i < n; i++) step(1, $urandom, 0, 2'd0, 0, 32'd0);
    endtask

    task automatic drain(int n);
        for (int i = 0; i < n; i++) step(0, 32'd0, 1, 2'd0, 0, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        peek_stat();
        chk("R11 reset status", cfg_rdata, 32'h0003_0000);
        chk("R11 reset err_out", {31'b0, err_out}, 32'd0);
        chk("R11 reset drain_req", {31'b0, drain_req}, 32'd1);

        // overflow with waiting disabled
        fill(DEP);
        step(1, 32'hDEAD_0001, 0, 2'd0, 0, 32'd0);
        peek_stat();
        chk("R4 overflow flag", {31'b0, cfg_rdata[20]}, 32'd1);
        chk("R4 word dropped, still full", {31'b0, fifo_full}, 32'd1);

        // clear and new overflow in the same cycle
        step(1, 32'hDEAD_0002, 0, 2'd0, 1, 32'h0010_0000);
        peek_stat();
        chk("R7 collision keeps overflow", {31'b0, cfg_rdata[20]}, 32'd1);
        step(0, 32'd0, 0, 2'd0, 1, 32'h0010_0000);
        peek_stat();
        chk("R7 lone clear", {31'b0, cfg_rdata[20]}, 32'd0);

        // masking
        step(0, 32'd0, 0, 2'd1, 1, 32'h0000_0070);
        step(1, 32'hDEAD_0003, 0, 2'd0, 0, 32'd0);
        peek_stat();
        chk("R8 masked err_out low", {31'b0, err_out}, 32'd0);
        chk("R8 masked flag reads set", {31'b0, cfg_rdata[20]}, 32'd1);
        step(0, 32'd0, 0, 2'd1, 1, 32'h0000_0000);
        chk("R8 unmasked err_out high", {31'b0, err_out}, 32'd1);

        // drain and underflow
        drain(DEP);
        step(0, 32'd0, 1, 2'd0, 0, 32'd0);
        peek_stat();
        chk("R3 underflow flag", {31'b0, cfg_rdata[21]}, 32'd1);

        // wait handshake
        step(0, 32'd0, 0, 2'd1, 1, 32'h0000_0002);
        fill(DEP);
        step(1, 32'hBEEF_0001, 0, 2'd0, 0, 32'd0);
        peek_stat();
        chk("R5 wait flag", {31'b0, cfg_rdata[22]}, 32'd1);
        drain(DEP);

        // soft reset with concurrent write
        fill(5);
        step(1, 32'hCAFE_0001, 0, 2'd1, 1, 32'h0000_0001);
        peek_stat();
        chk("R10 soft reset status", cfg_rdata, 32'h0003_0000);

        // watermark alarm with hold and re-evaluation
        step(0, 32'd0, 0, 2'd2, 1, 32'd4);
        step(0, 32'd0, 0, 2'd0, 1, 32'h0002_0000);
        chk("R6 re-evaluated low", {31'b0, drain_req}, 32'd0);
        fill(3);
        chk("R6 below watermark", {31'b0, drain_req}, 32'd0);
        fill(1);
        chk("R6 at watermark", {31'b0, drain_req}, 32'd1);
        drain(4);
        chk("R6 held after drain", {31'b0, drain_req}, 32'd1);
        step(0, 32'd0, 0, 2'd0, 1, 32'h0002_0000);
        chk("R6 released by re-evaluation", {31'b0, drain_req}, 32'd0);
        step(0, 32'd0, 0, 2'd2, 1, 32'd20);
        fill(DEP);
        chk("R6 watermark above depth", {31'b0, drain_req}, 32'd0);

        // seeded random phase
        for (int ph = 0; ph < 16; ph++) begin
            int pw = (ph % 2 == 0) ? 70 : 30;
            int pr = (ph % 2 == 0) ? 30 : 70;
            for (int i = 0; i < 200; i++) begin
                int r = int'($urandom % 64);
                bit wv = ($urandom % 100) < pw;
                bit re = ($urandom % 100) < pr;
                logic [31:0] wd = $urandom;
                if (r < 3)
                    step(wv, wd, re, 2'd0, 1, $urandom & 32'h0076_0000);
                else if (r == 3)
                    step(wv, wd, re, 2'd1, 1, ($urandom & 32'h72) | (($urandom % 4 == 0) ? 32'd1 : 32'd0));
                else if (r == 4)
                    step(wv, wd, re, 2'd2, 1, $urandom % 21);
                else
                    step(wv, wd, re, 2'($urandom % 4), 0, 32'd0);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule